// File: doc/BRIEF.md
# Codec Channel Power-Down Sequencer

This block decides whether a voice codec channel is powered up or in standby. It watches three external inputs: a dual-purpose pin that carries either the receive master clock or a static power-down level, and the transmit and receive frame-sync strobes. From these it drives a power-down flag for the rest of the chip. It also drives an enable qualifier for the serial PCM output, which stays in high impedance for a short time after wake-up. A third output reports whether the receive path is clocked from the dual-purpose pin or from the transmit master clock.

All three inputs pass through synchronizers into the free-running system clock domain. The pin counts as static when no edge appears on it for `STATIC_WIN` system clocks. If it is static and high, the channel is held in standby. If it is static and low, the receive path borrows the transmit master clock. If the pin keeps toggling, it serves as the receive master clock.

A second way into standby is the loss of frame sync. A timer of `TIMEOUT_US` microseconds, sized from `CLK_HZ`, is reloaded by every frame-sync rising edge. When the timer runs out, the channel drops to standby.

Top module: `codec_pwr_seq`

## Requirements
- R1: While reset is applied and just after it, `powerDown` is 1, `dataOutEn` is 0 and `rxOwnClk` is 0.
- R2: The block leaves standby only on a synchronized rising edge of `fsTx` or `fsRx`, and only while the pin is not static high. Without such an edge it stays in standby.
- R3: The pin counts as static high when it has shown no edge for `STATIC_WIN` system clocks and its level is 1. In that condition the block enters standby and stays there, even while frame syncs keep arriving.
- R4: Any frame-sync rising edge, transmit or receive, reloads the timeout. If `TIMEOUT_US` microseconds of system clock pass with no such edge, the block enters standby.
- R5: `dataOutEn` goes to 1 only while the block is active, and only once the second transmit frame-sync rising edge since wake-up has been seen. The pulse that wakes the block counts as the first. Receive frame syncs never count.
- R6: Every entry into standby clears the transmit frame-sync count. After a later wake-up, two new transmit pulses are needed before `dataOutEn` returns.
- R7: `rxOwnClk` is 1 while the pin shows edges within the static window, and 0 once it has been static, at either level.
- R8: A static low level on the pin does not cause standby. With frame syncs present, the block stays active and `rxOwnClk` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ckPin | input | 1 | Receive master clock, or a static standby/clock-select level |
| fsTx | input | 1 | Transmit frame-sync strobe (asynchronous) |
| fsRx | input | 1 | Receive frame-sync strobe (asynchronous) |
| powerDown | output | 1 | 1 while the channel is in standby |
| dataOutEn | output | 1 | 1 when the serial PCM output may be driven |
| rxOwnClk | output | 1 | 1 when the pin toggles and clocks the receive path |

## Verification
The bench moves the pin from low to high while frame syncs are still arriving. A design that treated the level as static too early, or that ignored a static high, would either never wake or would stay active against the standby request.

It wakes the channel with receive syncs only, and also re-wakes it after a standby. A design that counted receive pulses, or failed to clear the transmit count on entering standby, would enable the data output at once.

The timeout is probed a few cycles before and after expiry. A timer that was never reloaded, or that was reloaded only by transmit pulses, drops the channel at the wrong point.

A reset applied while the channel is active checks that the standby state and output qualifier return at once.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic {
    PS_DOWN   = 1'b0,
    PS_ACTIVE = 1'b1
  } pwrState_e;

  // status presented by the datapath to the control
  typedef struct packed {
    logic fsRise;
    logic fsTxRise;
    logic pinStatic;
    logic pinStaticHigh;
    logic timedOut;
    logic txTwice;
  } dpStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fsCntClr;
    logic fsCntInc;
  } ctlStrb_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[STAGES-2:0], d};
  end

  assign q = shiftReg[STAGES-1];
endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STATIC_WIN     = 16,
  parameter int TIMEOUT_CYCLES = 400000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ckPinIn,
  input  logic     fsTxIn,
  input  logic     fsRxIn,
  input  ctlStrb_t strb,
  output dpStat_t  stat
);
  localparam int N_IN   = 3;
  localparam int SW_W   = $clog2(STATIC_WIN + 1);
  localparam int TMR_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int IDX_PIN = 2;
  localparam int IDX_TX  = 1;
  localparam int IDX_RX  = 0;

  logic [N_IN-1:0] rawIn, syncIn, prevIn, edgeIn, riseIn;
  logic [SW_W-1:0]  staticCnt;
  logic [TMR_W-1:0] timer;
  logic [1:0]       txCnt;

  assign rawIn = {ckPinIn, fsTxIn, fsRxIn};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncIn[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  assign edgeIn = syncIn ^ prevIn;
  assign riseIn = syncIn & ~prevIn;

  // pin activity window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               staticCnt <= SW_W'(STATIC_WIN);
    else if (edgeIn[IDX_PIN])                staticCnt <= '0;
    else if (staticCnt != SW_W'(STATIC_WIN)) staticCnt <= staticCnt + 1'b1;
  end

  // frame-sync loss timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         timer <= '0;
    else if (stat.fsRise)              timer <= TMR_W'(TIMEOUT_CYCLES);
    else if (timer != '0)              timer <= timer - 1'b1;
  end

  // transmit frame-sync counter, saturating at two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            txCnt <= '0;
    else if (strb.fsCntClr)               txCnt <= '0;
    else if (strb.fsCntInc && txCnt != 2'd2) txCnt <= txCnt + 1'b1;
  end

  assign stat.fsRise        = riseIn[IDX_TX] | riseIn[IDX_RX];
  assign stat.fsTxRise      = riseIn[IDX_TX];
  assign stat.pinStatic     = (staticCnt == SW_W'(STATIC_WIN));
  assign stat.pinStaticHigh = stat.pinStatic & prevIn[IDX_PIN];
  assign stat.timedOut      = (timer == '0);
  assign stat.txTwice       = (txCnt == 2'd2);
endmodule

// File: rtl/pwrseq_ctl.sv
module pwrseq_ctl
  import pwrseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStat_t  stat,
  output ctlStrb_t strb,
  output logic     powerDown,
  output logic     dataOutEn
);
  pwrState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      PS_DOWN:
        if (stat.fsRise && !stat.pinStaticHigh) nextState = PS_ACTIVE;
      PS_ACTIVE:
        if (stat.pinStaticHigh || (stat.timedOut && !stat.fsRise))
          nextState = PS_DOWN;
      default: nextState = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_DOWN;
    else       state <= nextState;
  end

  assign strb.fsCntClr = (nextState == PS_DOWN);
  assign strb.fsCntInc = stat.fsTxRise;
  assign powerDown     = (state == PS_DOWN);
  assign dataOutEn     = (state == PS_ACTIVE) && stat.txTwice;
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int TIMEOUT_US  = 2000,
  parameter int STATIC_WIN  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ckPin,
  input  logic fsTx,
  input  logic fsRx,
  output logic powerDown,
  output logic dataOutEn,
  output logic rxOwnClk
);
  localparam int TIMEOUT_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  dpStat_t  stat;
  ctlStrb_t strb;

  pwrseq_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .STATIC_WIN    (STATIC_WIN),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ckPinIn(ckPin),
    .fsTxIn (fsTx),
    .fsRxIn (fsRx),
    .strb   (strb),
    .stat   (stat)
  );

  pwrseq_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .strb     (strb),
    .powerDown(powerDown),
    .dataOutEn(dataOutEn)
  );

  assign rxOwnClk = ~stat.pinStatic;
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk #(
  parameter int STATIC_WIN     = 16,
  parameter int TIMEOUT_CYCLES = 400000
) (
  input logic clk,
  input logic rstN,
  input logic ckPin,
  input logic fsTx,
  input logic fsRx,
  input logic powerDown,
  input logic dataOutEn,
  input logic rxOwnClk
);
  localparam int PIN_MARGIN = STATIC_WIN + 6;
  localparam int FS_MARGIN  = TIMEOUT_CYCLES + 6;

  int unsigned hiRun, pinQuiet, fsQuiet;
  logic        pinLast;
  logic [5:0]  fsHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun    <= 0;
      pinQuiet <= 0;
      fsQuiet  <= 0;
      pinLast  <= 1'b0;
      fsHist   <= '0;
    end else begin
      pinLast <= ckPin;
      fsHist  <= {fsHist[4:0], fsTx | fsRx};
      hiRun   <= !ckPin ? 0 : (hiRun < PIN_MARGIN + 1 ? hiRun + 1 : hiRun);
      pinQuiet <= (ckPin != pinLast) ? 0 :
                  (pinQuiet < PIN_MARGIN + 1 ? pinQuiet + 1 : pinQuiet);
      fsQuiet <= (fsTx | fsRx) ? 0 :
                 (fsQuiet < FS_MARGIN + 1 ? fsQuiet + 1 : fsQuiet);
    end
  end

  AST_RESET_STANDBY: assert property (@(posedge clk)
    !rstN |=> (powerDown && !dataOutEn)); // R1

  AST_WAKE_NEEDS_FS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerDown) |-> (fsHist != '0)); // R2

  AST_STATIC_HIGH_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (hiRun > PIN_MARGIN) |-> powerDown); // R3

  AST_FS_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (fsQuiet > FS_MARGIN) |-> powerDown); // R4

  AST_OE_NOT_AT_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOutEn) |-> !$past(powerDown)); // R5

  AST_QUIET_PIN_NOT_OWN: assert property (@(posedge clk) disable iff (!rstN)
    (pinQuiet > PIN_MARGIN) |-> !rxOwnClk); // R7
endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(
  .STATIC_WIN    (STATIC_WIN),
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ckPin    (ckPin),
  .fsTx     (fsTx),
  .fsRx     (fsRx),
  .powerDown(powerDown),
  .dataOutEn(dataOutEn),
  .rxOwnClk (rxOwnClk)
);

// File: tb/codec_pwr_seq_tb.sv
module codec_pwr_seq_tb;
  // 4 MHz nominal rate x 10 us -> 40-cycle timeout
  localparam int CLK_HZ     = 4_000_000;
  localparam int TIMEOUT_US = 10;
  localparam int STATIC_WIN = 16;
  localparam int N_VEC      = 10;

  // {pinMode[1:0] (0 low,1 high,2 toggle), fsMode[1:0] (b0 tx, b1 rx),
  //  cycles[7:0], expPd, expOe, expOwn}
  localparam logic [14:0] VEC [N_VEC] = '{
    {2'd0, 2'd0, 8'd30, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'd1, 8'd40, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'd3, 8'd40, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd1, 8'd40, 1'b0, 1'b1, 1'b0},
    {2'd2, 2'd1, 8'd40, 1'b0, 1'b1, 1'b1},
    {2'd2, 2'd0, 8'd60, 1'b1, 1'b0, 1'b1},
    {2'd2, 2'd2, 8'd40, 1'b0, 1'b0, 1'b1},
    {2'd2, 2'd1, 8'd40, 1'b0, 1'b1, 1'b1},
    {2'd1, 2'd1, 8'd40, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd0, 8'd60, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN, ckPin, fsTx, fsRx;
  logic powerDown, dataOutEn, rxOwnClk;
  int   nChecks = 0;
  int   nFail   = 0;

  always #2.5 clk = ~clk;

  codec_pwr_seq #(
    .CLK_HZ    (CLK_HZ),
    .TIMEOUT_US(TIMEOUT_US),
    .STATIC_WIN(STATIC_WIN)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .ckPin    (ckPin),
    .fsTx     (fsTx),
    .fsRx     (fsRx),
    .powerDown(powerDown),
    .dataOutEn(dataOutEn),
    .rxOwnClk (rxOwnClk)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic string vecReq(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R8";
      4: return "R7";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fsTx = 1'b0;
      fsRx = 1'b0;
    end
  endtask

  task automatic txPulse();
    @(negedge clk);
    fsTx = 1'b1;
    @(negedge clk);
    fsTx = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; ckPin = 1'b0; fsTx = 1'b0; fsRx = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "reset powerDown", powerDown, 1'b1);
    check("R1", "reset dataOutEn", dataOutEn, 1'b0);
    check("R1", "reset rxOwnClk", rxOwnClk, 1'b0);
    rstN = 1'b1;

    for (int v = 0; v < N_VEC; v++) begin
      for (int c = 0; c < int'(VEC[v][10:3]); c++) begin
        @(negedge clk);
        case (VEC[v][14:13])
          2'd0:    ckPin = 1'b0;
          2'd1:    ckPin = 1'b1;
          default: ckPin = c[1];
        endcase
        fsTx = VEC[v][11] && (c % 8 == 0);
        fsRx = VEC[v][12] && (c % 8 == 0);
      end
      @(negedge clk);
      fsTx = 1'b0;
      fsRx = 1'b0;
      check(vecReq(v), $sformatf("vec%0d powerDown", v), powerDown, VEC[v][2]);
      check(vecReq(v), $sformatf("vec%0d dataOutEn", v), dataOutEn, VEC[v][1]);
      check(vecReq(v), $sformatf("vec%0d rxOwnClk", v), rxOwnClk, VEC[v][0]);
    end

    // pin static low, standby: one tx pulse wakes, output still off
    txPulse();
    idle(8);
    check("R2", "wake on single tx pulse", powerDown, 1'b0);
    check("R5", "oe after first tx pulse", dataOutEn, 1'b0);
    txPulse();
    idle(8);
    check("R5", "oe after second tx pulse", dataOutEn, 1'b1);
    // timeout: ~10 cycles since pulse so far; probe before and after 40
    idle(20);
    check("R4", "still active before timeout", powerDown, 1'b0);
    idle(25);
    check("R4", "standby after timeout", powerDown, 1'b1);
    check("R4", "oe off after timeout", dataOutEn, 1'b0);
    // re-wake: count must have been cleared
    txPulse();
    idle(8);
    check("R6", "re-wake active", powerDown, 1'b0);
    check("R6", "oe off after re-wake", dataOutEn, 1'b0);
    // reset while active
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    check("R1", "mid-run reset powerDown", powerDown, 1'b1);
    check("R1", "mid-run reset dataOutEn", dataOutEn, 1'b0);
    rstN = 1'b1;
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule